// File: doc/BRIEF.md
# DDR Refresh Command Sequencer

This block runs one auto-refresh transaction on a DDR SDRAM command bus while rows may still be open. When the controller arbiter raises a request, the block stores the precharge delay, the refresh cycle time and a record of which banks hold an open row (with each row address). It then closes every bank with one precharge-all command and waits the precharge delay. Next it issues auto-refresh, waits the refresh cycle time and reopens each row that was open before, so the next transaction finds the pages as it left them.

The arbiter sees a busy flag for the whole transaction and a one-cycle done pulse when it ends. Clock enable is held high. The block has no data, strobe or mask outputs. Command outputs are decoded from state registers, so each command appears in the cycle after the clock edge that caused it.

Top module: `ddr_refresh_seq`

## Requirements
- R1: After reset, and whenever no transaction is running, busy and done are 0, every chip select is 1, RAS/CAS/WE read 111 (NOP), and address and bank are 0.
- R2: A request is accepted at a rising edge where req_i is 1 and busy_o is 0. The cycle after that edge carries PRECHARGE (RAS/CAS/WE = 010) with address bit 10 set and all other address bits 0, bank 0, all chip selects 0 and busy 1.
- R3: AUTO REFRESH (RAS/CAS/WE = 001, address 0, bank 0) is issued exactly RP cycles after the PRECHARGE cycle, for RP from 1 to 4. The RP-1 cycles between carry NOP (111) with chip selects 0 and address 0.
- R4: Exactly RFC NOP cycles (111, chip selects 0, address 0, bank 0) follow the AUTO REFRESH, for RFC from 1 to 15.
- R5: After the RFC wait, one ACTIVATE (RAS/CAS/WE = 011) is issued for each bank marked open at acceptance, one per consecutive cycle, in ascending bank index. Each carries that bank's stored row on the address and its index on the bank output. No ACTIVATE is issued for a bank marked closed.
- R6: done_o is 1 for exactly one cycle, the cycle after the last ACTIVATE, or after the last RFC NOP when no bank was open. In that cycle busy is still 1, chip selects are 1 and the command is NOP. The cycle after that is idle as in R1.
- R7: While busy_o is 1, including the done cycle, req_i, RP, RFC and the open-row record have no effect on the command stream of the running transaction.
- R8: cke_o is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Refresh request from the arbiter |
| rp_i | input | 3 | Precharge delay in cycles (1 to 4) |
| rfc_i | input | 4 | Refresh cycle time in cycles (1 to 15) |
| open_vld_i | input | BANK_N (4) | One bit per bank; 1 means that bank holds an open row |
| open_row_i | input | BANK_N*ROW_W (56) | Open row per bank, bank b in bits [b*ROW_W +: ROW_W] |
| busy_o | output | 1 | High from the precharge cycle through the done cycle |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| cke_o | output | 1 | Clock enable, held high |
| cs_n_o | output | RANKS (2) | Active-low chip selects, one per rank |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ROW_W (14) | Command address |
| ba_o | output | BANK_W (2) | Bank address |

## Verification
The assertions assume that at each accepted request RP lies in 1 to 4 and RFC in 1 to 15. The block stores these values without clamping them, and one assertion flags a request made with values outside that range. The stimulus sweeps every legal RP and RFC pair and never drives an illegal value. It changes the request, the timing inputs and the open-row record while a transaction is running, because the stored copies must not follow them.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;

    localparam int RP_W  = 3;
    localparam int RFC_W = 4;
    localparam int CNT_W = 4;

    // RAS/CAS/WE encodings
    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_PRE = 3'b010,
        CMD_REF = 3'b001,
        CMD_ACT = 3'b011
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_TRP,
        S_REF,
        S_TRFC,
        S_ACT,
        S_DONE
    } seq_st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic strobe_t cmd_strobes(input cmd_e c);
        strobe_t s;
        s.ras_n = c[2];
        s.cas_n = c[1];
        s.we_n  = c[0];
        return s;
    endfunction

    // a sequence state puts chip select low on every rank
    function automatic logic st_drives_bus(input seq_st_e s);
        return (s != S_IDLE) && (s != S_DONE);
    endfunction

endpackage

// File: rtl/ddr_ref_timer.sv
module ddr_ref_timer
    import ddr_ref_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);   // R4

endmodule

// File: rtl/ddr_ref_bank_pick.sv
module ddr_ref_bank_pick #(
    parameter int BANK_N = 4,
    localparam int BANK_W = (BANK_N > 1) ? $clog2(BANK_N) : 1
) (
    input  logic [BANK_N-1:0] mask,
    output logic [BANK_W-1:0] idx,
    output logic              any,
    output logic [BANK_N-1:0] grant,
    output logic              last
);

    // lowest set bit wins
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int b = BANK_N - 1; b >= 0; b--) begin
            if (mask[b]) begin
                idx = b[BANK_W-1:0];
                any = 1'b1;
            end
        end
        grant = any ? (BANK_N'(1) << idx) : '0;
        last  = ((mask & ~grant) == '0);
    end

    always_comb begin
        AST_PICK_ONEHOT: assert ($onehot0(grant) && ((grant & ~mask) == '0));   // R5
    end

endmodule

// File: rtl/ddr_ref_cmd_drv.sv
module ddr_ref_cmd_drv
    import ddr_ref_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 2,
    parameter int RANKS  = 2,
    parameter int AP_BIT = 10
) (
    input  cmd_e              cmd,
    input  logic              sel,
    input  logic [ROW_W-1:0]  row,
    input  logic [BANK_W-1:0] bank,
    output logic [RANKS-1:0]  cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ROW_W-1:0]  addr,
    output logic [BANK_W-1:0] ba
);

    strobe_t stb;

    always_comb begin
        stb  = cmd_strobes(cmd);
        cs_n = sel ? '0 : '1;
        addr = '0;
        ba   = '0;
        unique case (cmd)
            CMD_ACT: begin
                addr = row;
                ba   = bank;
            end
            CMD_PRE: addr[AP_BIT] = 1'b1;
            default: ;
        endcase
    end

    assign ras_n = stb.ras_n;
    assign cas_n = stb.cas_n;
    assign we_n  = stb.we_n;

endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
    import ddr_ref_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_N = 4,
    parameter int RANKS  = 2,
    parameter int AP_BIT = 10,
    localparam int BANK_W = (BANK_N > 1) ? $clog2(BANK_N) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_i,
    input  logic [RP_W-1:0]         rp_i,
    input  logic [RFC_W-1:0]        rfc_i,
    input  logic [BANK_N-1:0]       open_vld_i,
    input  logic [BANK_N*ROW_W-1:0] open_row_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    cke_o,
    output logic [RANKS-1:0]        cs_n_o,
    output logic                    ras_n_o,
    output logic                    cas_n_o,
    output logic                    we_n_o,
    output logic [ROW_W-1:0]        addr_o,
    output logic [BANK_W-1:0]       ba_o
);

    seq_st_e            st_q, st_d;
    logic [RP_W-1:0]    rp_q;
    logic [RFC_W-1:0]   rfc_q;
    logic [BANK_N-1:0]  pend_q;
    logic [ROW_W-1:0]   row_q [BANK_N];

    logic               accept;
    logic               tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0]   tmr_val;
    logic [BANK_W-1:0]  pick_idx;
    logic               pick_any, pick_last;
    logic [BANK_N-1:0]  pick_grant;
    cmd_e               cmd;

    assign accept = req_i && (st_q == S_IDLE);

    // stored copies of the configuration and open-row record
    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q  <= RP_W'(1);
            rfc_q <= RFC_W'(1);
        end else if (accept) begin
            rp_q  <= rp_i;
            rfc_q <= rfc_i;
        end
    end

    generate
        for (genvar b = 0; b < BANK_N; b++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst) begin
                    row_q[b] <= '0;
                end else if (accept) begin
                    row_q[b] <= open_row_i[b*ROW_W +: ROW_W];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (accept) begin
            pend_q <= open_vld_i;
        end else if (st_q == S_ACT) begin
            pend_q <= pend_q & ~pick_grant;
        end
    end

    ddr_ref_bank_pick #(.BANK_N(BANK_N)) u_pick (
        .mask  (pend_q),
        .idx   (pick_idx),
        .any   (pick_any),
        .grant (pick_grant),
        .last  (pick_last)
    );

    ddr_ref_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    // sequence control
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        unique case (st_q)
            S_IDLE: if (req_i) st_d = S_PRE;
            S_PRE: begin
                if (rp_q <= RP_W'(1)) begin
                    st_d = S_REF;
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'({1'b0, rp_q} - 4'd2);
                    st_d     = S_TRP;
                end
            end
            S_TRP: begin
                tmr_dec = 1'b1;
                if (tmr_zero) st_d = S_REF;
            end
            S_REF: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(rfc_q - RFC_W'(1));
                st_d     = S_TRFC;
            end
            S_TRFC: begin
                tmr_dec = 1'b1;
                if (tmr_zero) st_d = (pend_q != '0) ? S_ACT : S_DONE;
            end
            S_ACT:  if (pick_last) st_d = S_DONE;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            S_PRE:   cmd = CMD_PRE;
            S_REF:   cmd = CMD_REF;
            S_ACT:   cmd = pick_any ? CMD_ACT : CMD_NOP;
            default: cmd = CMD_NOP;
        endcase
    end

    ddr_ref_cmd_drv #(
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W),
        .RANKS  (RANKS),
        .AP_BIT (AP_BIT)
    ) u_drv (
        .cmd   (cmd),
        .sel   (st_drives_bus(st_q)),
        .row   (row_q[pick_idx]),
        .bank  (pick_idx),
        .cs_n  (cs_n_o),
        .ras_n (ras_n_o),
        .cas_n (cas_n_o),
        .we_n  (we_n_o),
        .addr  (addr_o),
        .ba    (ba_o)
    );

    assign busy_o = (st_q != S_IDLE);
    assign done_o = (st_q == S_DONE);
    assign cke_o  = 1'b1;

    // input contract at acceptance
    AST_CFG_RANGE: assert property (@(posedge clk) disable iff (rst)
        accept |-> (rp_i >= RP_W'(1)) && (rp_i <= RP_W'(4)) && (rfc_i != '0));   // R3

    AST_PRE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_i && !busy_o) |=> ({ras_n_o, cas_n_o, we_n_o} == 3'b010) && addr_o[AP_BIT] && (cs_n_o == '0));   // R2

    AST_REF_AFTER_TRP: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_TRP && tmr_zero) |=> ({ras_n_o, cas_n_o, we_n_o} == 3'b001));   // R3

    AST_ACT_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (({ras_n_o, cas_n_o, we_n_o} == 3'b011) && $past({ras_n_o, cas_n_o, we_n_o} == 3'b011))
            |-> (ba_o > $past(ba_o)));   // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));   // R6

    AST_CS_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (cs_n_o == '0) || (cs_n_o == '1));   // R2

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ($stable(rp_q) && $stable(rfc_q)));   // R7

endmodule

// File: tb/sim_ddr_refresh_seq.sv
module sim_ddr_refresh_seq;

    localparam int ROW_W  = 14;
    localparam int BANK_N = 4;
    localparam int RANKS  = 2;

    typedef struct packed {
        logic [1:0]  cs;
        logic [2:0]  cmd;
        logic [13:0] addr;
        logic [1:0]  ba;
        logic        busy;
        logic        done;
    } obs_t;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req = 1'b0;
    logic [2:0]              rp  = 3'd1;
    logic [3:0]              rfc = 4'd1;
    logic [BANK_N-1:0]       vld = '0;
    logic [BANK_N*ROW_W-1:0] rows = '0;
    logic                    busy, done, cke, ras_n, cas_n, we_n;
    logic [RANKS-1:0]        cs_n;
    logic [ROW_W-1:0]        addr;
    logic [1:0]              ba;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit cur_idle = 1;
    bit poke = 0;
    obs_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    ddr_refresh_seq u0 (
        .clk(clk), .rst(rst), .req_i(req), .rp_i(rp), .rfc_i(rfc),
        .open_vld_i(vld), .open_row_i(rows),
        .busy_o(busy), .done_o(done), .cke_o(cke), .cs_n_o(cs_n),
        .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .addr_o(addr), .ba_o(ba)
    );

    function automatic obs_t mk(logic sel, logic [2:0] c, logic [13:0] a,
                                logic [1:0] b, logic bz, logic dn);
        obs_t o;
        o.cs = sel ? 2'b00 : 2'b11;
        o.cmd = c; o.addr = a; o.ba = b; o.busy = bz; o.done = dn;
        return o;
    endfunction

    function automatic logic [13:0] row_of(int seed, int b);
        return 14'((seed * 37 + b * 1111 + 5) % 16384);
    endfunction

    task automatic push(obs_t o, string t);
        exp_q.push_back(o);
        tag_q.push_back(t);
    endtask

    // expected transaction, built from the requirements
    task automatic build(int p, int f, logic [BANK_N-1:0] v, logic [BANK_N*ROW_W-1:0] r);
        push(mk(1, 3'b010, 14'h0400, 2'd0, 1, 0), "R2");
        for (int i = 1; i < p; i++) push(mk(1, 3'b111, 14'd0, 2'd0, 1, 0), "R3");
        push(mk(1, 3'b001, 14'd0, 2'd0, 1, 0), "R3");
        for (int i = 0; i < f; i++) push(mk(1, 3'b111, 14'd0, 2'd0, 1, 0), "R4");
        for (int b = 0; b < BANK_N; b++)
            if (v[b]) push(mk(1, 3'b011, r[b*ROW_W +: ROW_W], 2'(b), 1, 0), "R5");
        push(mk(0, 3'b111, 14'd0, 2'd0, 1, 1), "R6");
    endtask

    task automatic compare();
        obs_t e, a;
        string t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            cur_idle = 0;
            if (poke) t = "R7";
        end else begin
            e = mk(0, 3'b111, 14'd0, 2'd0, 0, 0);
            t = "R1";
            cur_idle = 1;
        end
        a.cs = cs_n; a.cmd = {ras_n, cas_n, we_n}; a.addr = addr; a.ba = ba;
        a.busy = busy; a.done = done;
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
        checks++;
        if (cke !== 1'b1) begin
            failures++;
            $display("FAIL R8 cke actual=%b expected=1", cke);
        end
    endtask

    task automatic cyc(logic r, int p, int f, logic [BANK_N-1:0] v, int seed);
        @(negedge clk);
        compare();
        req = r; rp = 3'(p); rfc = 4'(f); vld = v;
        for (int b = 0; b < BANK_N; b++) rows[b*ROW_W +: ROW_W] = row_of(seed, b);
        if (cur_idle && r) begin
            poke = 0;
            build(p, f, v, rows);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) cyc(0, 1, 1, '0, 0);
        cyc(0, 1, 1, '0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) cyc(0, 1, 1, '0, 0);          // R1 reset state

        for (int p = 1; p <= 4; p++) begin       // R3 R4 R5 sweep
            for (int f = 1; f <= 15; f++) begin
                cyc(1, p, f, 4'((p * 5 + f) % 16), p * 16 + f);
                drain();
            end
        end

        cyc(1, 1, 1, 4'hF, 901); drain();        // R5 every bank open
        cyc(1, 4, 15, 4'h0, 902); drain();       // R6 no bank open
        cyc(1, 3, 2, 4'b1000, 903); drain();     // R5 highest bank only

        // R7: request and inputs change during a running transaction
        cyc(1, 2, 3, 4'b0101, 904);
        poke = 1;
        while (exp_q.size() > 0) cyc(1, 4, 9, 4'hF, 905);
        drain();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule